// File: doc/BRIEF.md
# Masked Packed Logical Left Shifter

This unit shifts every element of a 512-bit vector left by one common count, filling the vacated low bits with zeros, and never lets bits travel into the neighbouring element. Elements are 16, 32 or 64 bits wide. The count comes either from a 64-bit register operand or from an 8-bit immediate. A count at or beyond the element width gives zero rather than wrapping. After the shift, a per-element write mask selects the result. A masked-off element either keeps the previous destination value (merge) or is cleared (zero). The active vector length (128, 256 or 512 bits) and an encoding-mode input then decide what happens to the destination bits above the active length.

In extended mode the shift source is `src_vec`, masking and broadcast are available, and bits above the vector length are cleared. In legacy mode the shift source is the old destination itself. Only bits 127:0 are rewritten and everything above keeps its old value. In immediate-count operations on 32-bit or 64-bit elements, broadcast copies element 0 of the source into every lane before the shift. The result is captured in one output register. A two-state machine tracks whether that register holds a fresh result.

Output state machine: `ST_EMPTY` (no fresh result, `out_valid` low) and `ST_FULL` (fresh result, `out_valid` high). The transitions are:
- EMPTY→FULL on `in_valid`
- FULL→FULL on `in_valid`
- FULL→EMPTY without `in_valid`
- EMPTY→EMPTY without `in_valid`

Reset enters `ST_EMPTY`.

Top module: `simd_sll_unit`

## Requirements
- R1: Each element (size code 0 = 16 bits, 1 = 32 bits, 2 = 64 bits) is shifted left by the count with zeros filled in at the bottom; bits shifted out of an element are lost and never enter the next element.
- R2: A count greater than or equal to the element width makes every shifted element 0; this holds for the immediate count too (for example 255).
- R3: With `use_imm` = 0 the count is the full 64-bit unsigned `cnt_reg`, so values such as 2^40 or 2^63 give all-zero elements; with `use_imm` = 1 `cnt_reg` has no effect and the 8-bit `cnt_imm` is the count.
- R4: In extended mode with `mask_en` = 1, element j inside the active length takes the shifted value when `mask_bits[j]` is 1; when it is 0, the element keeps `old_dst` if `zero_mode` = 0 or becomes 0 if `zero_mode` = 1. With `mask_en` = 0 every active element takes the shifted value.
- R5: In extended mode (`ext_mode` = 1) the active length is 128, 256 or 512 bits for `vlen_sel` codes 0, 1, 2, and every output bit at or above that length is 0.
- R6: In legacy mode (`ext_mode` = 0) the shift source is `old_dst`, bits 127:0 carry the unmasked shift, bits 511:128 equal `old_dst`, and `mask_en`, `zero_mode`, `bcast_en` and a legal `vlen_sel` have no effect.
- R7: In extended mode with `bcast_en` = 1, `use_imm` = 1 and 32-bit or 64-bit elements, element 0 of `src_vec` is copied to every lane before the shift; broadcast has no effect for 16-bit elements or with a register count.
- R8: A size code of 3 or a length code of 3 gives an all-zero `out_data` with `out_illegal` = 1 in the result cycle.
- R9: A result sampled with `in_valid` appears on `out_data` one clock later with `out_valid` = 1; in a cycle without `in_valid` the next cycle has `out_valid` = 0 and `out_data` unchanged.
- R10: While `rst_n` is low (synchronous), `out_valid`, `out_illegal` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| src_vec | input | 512 | Shift source in extended mode |
| old_dst | input | 512 | Previous destination value |
| cnt_reg | input | 64 | Register count, unsigned |
| cnt_imm | input | 8 | Immediate count, unsigned |
| use_imm | input | 1 | 1 selects the immediate count |
| esize_sel | input | 2 | Element size code |
| vlen_sel | input | 2 | Vector length code |
| mask_bits | input | 32 | Per-element write mask, bit j for element j |
| mask_en | input | 1 | Enables masking |
| zero_mode | input | 1 | 1 clears masked-off elements, 0 merges |
| ext_mode | input | 1 | 1 extended mode, 0 legacy mode |
| bcast_en | input | 1 | Broadcast element 0 |
| out_valid | output | 1 | Fresh result on out_data |
| out_illegal | output | 1 | Result came from an illegal code |
| out_data | output | 512 | Registered result |

## Verification
The bench drives counts of zero, width-1, exactly the width, 255 and 2^63, plus 2^40 on the register path. A design that wrapped the count modulo the width, or looked at only the low byte of the register count, would return a shifted pattern where zero is expected. A sweep of all size and length pairs, using all-ones elements, exposes shifts that leak bits across element boundaries and upper bits that are not cleared. Merge and zero masking are run with random masks, which catches an inverted polarity or a mask index taken at the wrong granularity. Separate tasks cover several other errors:
- legacy mode shifting `src_vec` instead of the old destination;
- broadcast leaking into 16-bit or register-count cases;
- illegal codes producing data;
- a result that shows up a cycle late or is not held.

// File: rtl/simd_sll_pkg.sv
package simd_sll_pkg;

    localparam int NSIZE = 3;

    typedef enum logic [1:0] {
        ESZ_16  = 2'd0,
        ESZ_32  = 2'd1,
        ESZ_64  = 2'd2,
        ESZ_BAD = 2'd3
    } esize_e;

    typedef enum logic [1:0] {
        VL_128 = 2'd0,
        VL_256 = 2'd1,
        VL_512 = 2'd2,
        VL_BAD = 2'd3
    } vlen_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } ostate_e;

endpackage

// File: rtl/sll_count_unit.sv
module sll_count_unit #(
    parameter int CNT_W  = 64,
    parameter int IMM_W  = 8,
    parameter int GRAN_W = 16,
    parameter int NSIZE  = 3
) (
    input  logic [CNT_W-1:0] cnt_reg,
    input  logic [IMM_W-1:0] cnt_imm,
    input  logic             use_imm,
    output logic [$clog2(GRAN_W << (NSIZE-1))-1:0] shamt,
    output logic [NSIZE-1:0] over
);
    localparam int LG  = $clog2(GRAN_W);
    localparam int SHW = $clog2(GRAN_W << (NSIZE-1));

    logic [CNT_W-1:0] cnt;

    // Both count sources are treated as unsigned integers of full width.
    assign cnt   = use_imm ? CNT_W'(cnt_imm) : cnt_reg;
    assign shamt = cnt[SHW-1:0];

    // over[k]: count reaches the width of size k (16 << k bits).
    for (genvar k = 0; k < NSIZE; k++) begin : g_over
        assign over[k] = |cnt[CNT_W-1:LG+k];
    end

endmodule

// File: rtl/sll_lane_shifter.sv
module sll_lane_shifter #(
    parameter int VEC_W = 512,
    parameter int EW    = 16,
    parameter int SHW   = 6
) (
    input  logic [VEC_W-1:0] vec,
    input  logic [SHW-1:0]   shamt,
    input  logic             over,
    output logic [VEC_W-1:0] res
);
    localparam int NL = VEC_W / EW;

    // Every lane owns its own shifter, so bits cannot cross lanes.
    for (genvar j = 0; j < NL; j++) begin : g_lane
        assign res[j*EW +: EW] = over ? '0 : (vec[j*EW +: EW] << shamt);
    end

endmodule

// File: rtl/sll_mask_stage.sv
module sll_mask_stage #(
    parameter int VEC_W  = 512,
    parameter int GRAN_W = 16,
    parameter int N_GRAN = VEC_W / GRAN_W,
    parameter int AGW    = $clog2(N_GRAN) + 1
) (
    input  logic [VEC_W-1:0]  shifted,
    input  logic [VEC_W-1:0]  old_dst,
    input  logic [N_GRAN-1:0] mask_bits,
    input  logic [1:0]        esize,
    input  logic [AGW-1:0]    act_gran,
    input  logic              mask_on,
    input  logic              zero_mode,
    input  logic              ext_mode,
    input  logic              kill,
    output logic [VEC_W-1:0]  result
);
    // Work on 16-bit granules; each granule finds its element's mask bit.
    for (genvar g = 0; g < N_GRAN; g++) begin : g_gran
        localparam int I32 = g / 2;
        localparam int I64 = g / 4;
        localparam logic [AGW-1:0] GIDX = AGW'(g);

        logic mbit;
        logic in_vl;
        logic take;

        always_comb begin
            case (esize)
                2'd0:    mbit = mask_bits[g];
                2'd1:    mbit = mask_bits[I32];
                default: mbit = mask_bits[I64];
            endcase
        end

        assign in_vl = GIDX < act_gran;
        assign take  = !mask_on || mbit;

        always_comb begin
            if (kill)
                result[g*GRAN_W +: GRAN_W] = '0;
            else if (!in_vl)
                result[g*GRAN_W +: GRAN_W] = ext_mode ? '0 : old_dst[g*GRAN_W +: GRAN_W];
            else if (take)
                result[g*GRAN_W +: GRAN_W] = shifted[g*GRAN_W +: GRAN_W];
            else
                result[g*GRAN_W +: GRAN_W] = zero_mode ? '0 : old_dst[g*GRAN_W +: GRAN_W];
        end
    end

endmodule

// File: rtl/simd_sll_unit.sv
module simd_sll_unit
    import simd_sll_pkg::*;
#(
    parameter int VEC_W  = 512,
    parameter int CNT_W  = 64,
    parameter int IMM_W  = 8,
    parameter int GRAN_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [VEC_W-1:0]          src_vec,
    input  logic [VEC_W-1:0]          old_dst,
    input  logic [CNT_W-1:0]          cnt_reg,
    input  logic [IMM_W-1:0]          cnt_imm,
    input  logic                      use_imm,
    input  logic [1:0]                esize_sel,
    input  logic [1:0]                vlen_sel,
    input  logic [VEC_W/GRAN_W-1:0]   mask_bits,
    input  logic                      mask_en,
    input  logic                      zero_mode,
    input  logic                      ext_mode,
    input  logic                      bcast_en,
    output logic                      out_valid,
    output logic                      out_illegal,
    output logic [VEC_W-1:0]          out_data
);
    localparam int N_GRAN = VEC_W / GRAN_W;
    localparam int AGW    = $clog2(N_GRAN) + 1;
    localparam int MAXE   = GRAN_W << (NSIZE-1);
    localparam int SHW    = $clog2(MAXE);
    localparam int W32    = 2 * GRAN_W;
    localparam int W64    = 4 * GRAN_W;

    esize_e esz;
    vlen_e  vln;
    assign esz = esize_e'(esize_sel);
    assign vln = vlen_e'(vlen_sel);

    logic illegal;
    assign illegal = (esz == ESZ_BAD) || (vln == VL_BAD);

    // ---------------- count ----------------
    logic [SHW-1:0]   shamt;
    logic [NSIZE-1:0] over;

    sll_count_unit #(
        .CNT_W (CNT_W),
        .IMM_W (IMM_W),
        .GRAN_W(GRAN_W),
        .NSIZE (NSIZE)
    ) u_count (
        .cnt_reg(cnt_reg),
        .cnt_imm(cnt_imm),
        .use_imm(use_imm),
        .shamt  (shamt),
        .over   (over)
    );

    // ---------------- source select ----------------
    logic [VEC_W-1:0] rep32;
    logic [VEC_W-1:0] rep64;
    logic [VEC_W-1:0] base;
    logic             bc_active;

    for (genvar c = 0; c < VEC_W / W32; c++) begin : g_rep32
        assign rep32[c*W32 +: W32] = src_vec[W32-1:0];
    end
    for (genvar c = 0; c < VEC_W / W64; c++) begin : g_rep64
        assign rep64[c*W64 +: W64] = src_vec[W64-1:0];
    end

    assign bc_active = ext_mode && bcast_en && use_imm && (esz != ESZ_16);

    always_comb begin
        if (!ext_mode)
            base = old_dst;
        else if (bc_active)
            base = (esz == ESZ_32) ? rep32 : rep64;
        else
            base = src_vec;
    end

    // ---------------- shifters, one per element size ----------------
    logic [VEC_W-1:0] sh_arr [NSIZE];
    logic [VEC_W-1:0] shifted;

    for (genvar k = 0; k < NSIZE; k++) begin : g_shift
        sll_lane_shifter #(
            .VEC_W(VEC_W),
            .EW   (GRAN_W << k),
            .SHW  (SHW)
        ) u_lanes (
            .vec  (base),
            .shamt(shamt),
            .over (over[k]),
            .res  (sh_arr[k])
        );
    end

    always_comb begin
        case (esz)
            ESZ_16:  shifted = sh_arr[0];
            ESZ_32:  shifted = sh_arr[1];
            default: shifted = sh_arr[2];
        endcase
    end

    // ---------------- active length ----------------
    logic [AGW-1:0] act_gran;

    always_comb begin
        if (!ext_mode) begin
            act_gran = AGW'(N_GRAN / 4);
        end else begin
            case (vln)
                VL_128:  act_gran = AGW'(N_GRAN / 4);
                VL_256:  act_gran = AGW'(N_GRAN / 2);
                VL_512:  act_gran = AGW'(N_GRAN);
                default: act_gran = '0;
            endcase
        end
    end

    // ---------------- masking ----------------
    logic [VEC_W-1:0] masked;

    sll_mask_stage #(
        .VEC_W (VEC_W),
        .GRAN_W(GRAN_W),
        .N_GRAN(N_GRAN),
        .AGW   (AGW)
    ) u_mask (
        .shifted  (shifted),
        .old_dst  (old_dst),
        .mask_bits(mask_bits),
        .esize    (esize_sel),
        .act_gran (act_gran),
        .mask_on  (mask_en && ext_mode),
        .zero_mode(zero_mode),
        .ext_mode (ext_mode),
        .kill     (illegal),
        .result   (masked)
    );

    // ---------------- output stage state machine ----------------
    ostate_e          state_q;
    ostate_e          state_d;
    logic [VEC_W-1:0] data_q;
    logic             ill_q;

    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_EMPTY;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            ill_q  <= 1'b0;
        end else begin
            ill_q <= in_valid && illegal;
            if (in_valid)
                data_q <= masked;
        end
    end

    always_comb begin
        out_valid   = (state_q == ST_FULL);
        out_illegal = ill_q;
        out_data    = data_q;
    end

endmodule

// File: rtl/simd_sll_sva.sv
module simd_sll_sva #(
    parameter int VEC_W = 512,
    parameter int IMM_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [VEC_W-1:0] old_dst,
    input logic [IMM_W-1:0] cnt_imm,
    input logic             use_imm,
    input logic [1:0]       esize_sel,
    input logic [1:0]       vlen_sel,
    input logic             mask_en,
    input logic             ext_mode,
    input logic             out_valid,
    input logic             out_illegal,
    input logic [VEC_W-1:0] out_data
);
    localparam int LOW_W = 128;

    AST_FILL_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9

    AST_DRAIN_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data)); // R9

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> out_data == '0); // R8

    AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (esize_sel == 2'd3 || vlen_sel == 2'd3) |=> out_illegal); // R8

    AST_LEGACY_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !ext_mode && esize_sel != 2'd3 && vlen_sel != 2'd3
        |=> out_data[VEC_W-1:LOW_W] == $past(old_dst[VEC_W-1:LOW_W])); // R6

    AST_EXT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ext_mode && vlen_sel == 2'd0 && esize_sel != 2'd3
        |=> out_data[VEC_W-1:LOW_W] == '0); // R5

    AST_SAT_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ext_mode && use_imm && cnt_imm >= IMM_W'(64) && !mask_en
        && vlen_sel == 2'd2 && esize_sel != 2'd3
        |=> out_data == '0); // R2

endmodule

bind simd_sll_unit simd_sll_sva #(
    .VEC_W(VEC_W),
    .IMM_W(IMM_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .old_dst    (old_dst),
    .cnt_imm    (cnt_imm),
    .use_imm    (use_imm),
    .esize_sel  (esize_sel),
    .vlen_sel   (vlen_sel),
    .mask_en    (mask_en),
    .ext_mode   (ext_mode),
    .out_valid  (out_valid),
    .out_illegal(out_illegal),
    .out_data   (out_data)
);

// File: tb/simd_sll_unit_tb.sv
module simd_sll_unit_tb;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [511:0] src_vec;
    logic [511:0] old_dst;
    logic [63:0]  cnt_reg;
    logic [7:0]   cnt_imm;
    logic         use_imm;
    logic [1:0]   esize_sel;
    logic [1:0]   vlen_sel;
    logic [31:0]  mask_bits;
    logic         mask_en;
    logic         zero_mode;
    logic         ext_mode;
    logic         bcast_en;
    logic         out_valid;
    logic         out_illegal;
    logic [511:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    simd_sll_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .src_vec    (src_vec),
        .old_dst    (old_dst),
        .cnt_reg    (cnt_reg),
        .cnt_imm    (cnt_imm),
        .use_imm    (use_imm),
        .esize_sel  (esize_sel),
        .vlen_sel   (vlen_sel),
        .mask_bits  (mask_bits),
        .mask_en    (mask_en),
        .zero_mode  (zero_mode),
        .ext_mode   (ext_mode),
        .bcast_en   (bcast_en),
        .out_valid  (out_valid),
        .out_illegal(out_illegal),
        .out_data   (out_data)
    );

    // ---------------- reference model from the requirements ----------------
    function automatic logic [511:0] ref_calc();
        logic [511:0] r, sv;
        logic [63:0]  cnt, e, sh, m, ov;
        int ew, vlb, n, lo;
        logic take;
        if (esize_sel == 2'd3 || vlen_sel == 2'd3) return '0;
        ew  = 16 << esize_sel;
        vlb = ext_mode ? (128 << vlen_sel) : 128;
        cnt = use_imm ? {56'd0, cnt_imm} : cnt_reg;
        n   = 512 / ew;
        sv  = ext_mode ? src_vec : old_dst;
        if (ext_mode && bcast_en && use_imm && esize_sel != 2'd0)
            for (int j = 0; j < n; j++)
                for (int b = 0; b < ew; b++) sv[j*ew + b] = src_vec[b];
        m = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
        r = old_dst;
        for (int j = 0; j < n; j++) begin
            lo = j * ew;
            e  = '0;
            ov = '0;
            for (int b = 0; b < ew; b++) begin
                e[b]  = sv[lo + b];
                ov[b] = old_dst[lo + b];
            end
            if (lo >= vlb) begin
                if (ext_mode) for (int b = 0; b < ew; b++) r[lo + b] = 1'b0;
            end else begin
                sh   = (cnt >= 64'(ew)) ? 64'd0 : ((e << cnt) & m);
                take = !(ext_mode && mask_en) || mask_bits[j];
                if (!take) sh = zero_mode ? 64'd0 : ov;
                for (int b = 0; b < ew; b++) r[lo + b] = sh[b];
            end
        end
        return r;
    endfunction

    function automatic logic [511:0] rand512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [511:0] got, input logic [511:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", rq, what, got, exp);
        end
    endtask

    task automatic set_defaults();
        src_vec   = rand512();
        old_dst   = rand512();
        cnt_reg   = 64'd0;
        cnt_imm   = 8'd0;
        use_imm   = 1'b0;
        esize_sel = 2'd0;
        vlen_sel  = 2'd2;
        mask_bits = 32'd0;
        mask_en   = 1'b0;
        zero_mode = 1'b0;
        ext_mode  = 1'b1;
        bcast_en  = 1'b0;
    endtask

    // inputs are already set; issue one operation and check its result
    task automatic run_op(input string rq, input string what);
        logic [511:0] exp;
        logic         exp_ill;
        exp     = ref_calc();
        exp_ill = (esize_sel == 2'd3 || vlen_sel == 2'd3);
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9", {what, " valid"}, {511'd0, out_valid}, {511'd0, 1'b1});
        chk(rq, {what, " data"}, out_data, exp);
        chk(rq, {what, " illegal flag"}, {511'd0, out_illegal}, {511'd0, exp_ill});
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n    = 1'b0;
        in_valid = 1'b1;
        set_defaults();
        repeat (3) @(negedge clk);
        chk("R10", "reset valid", {511'd0, out_valid}, '0);
        chk("R10", "reset data", out_data, '0);
        chk("R10", "reset illegal", {511'd0, out_illegal}, '0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_sweep();
        int ew;
        for (int es = 0; es < 3; es++) begin
            for (int vl = 0; vl < 3; vl++) begin
                ew = 16 << es;
                set_defaults();
                esize_sel = 2'(es);
                vlen_sel  = 2'(vl);
                src_vec   = '1;
                cnt_reg   = 64'd4;
                run_op("R1", "all-ones no crossing, R5 upper clear");
                set_defaults();
                esize_sel = 2'(es);
                vlen_sel  = 2'(vl);
                cnt_reg   = 64'd0;
                run_op("R1", "count zero");
                cnt_reg = 64'(ew - 1);
                run_op("R1", "count width-1");
                cnt_reg = 64'(ew);
                run_op("R2", "count equal width");
                use_imm = 1'b1;
                cnt_imm = 8'd255;
                run_op("R2", "imm 255");
                cnt_imm = 8'(ew - 1);
                run_op("R1", "imm width-1");
                use_imm = 1'b0;
                cnt_reg = 64'h8000_0000_0000_0000;
                run_op("R3", "count 2^63");
            end
        end
    endtask

    task automatic t_regcount();
        for (int es = 0; es < 3; es++) begin
            set_defaults();
            esize_sel = 2'(es);
            cnt_reg   = 64'h0000_0100_0000_0000;
            run_op("R3", "count 2^40");
            cnt_reg = 64'h0000_0001_0000_0003;
            run_op("R3", "count with high bits over low 3");
            use_imm = 1'b1;
            cnt_imm = 8'd3;
            cnt_reg = '1;
            run_op("R3", "imm ignores register count");
        end
    endtask

    task automatic t_mask();
        for (int es = 0; es < 3; es++) begin
            for (int z = 0; z < 2; z++) begin
                for (int vl = 0; vl < 3; vl++) begin
                    set_defaults();
                    esize_sel = 2'(es);
                    vlen_sel  = 2'(vl);
                    mask_en   = 1'b1;
                    zero_mode = 1'(z);
                    mask_bits = $urandom;
                    cnt_reg   = 64'd3;
                    run_op("R4", z ? "zero masking" : "merge masking");
                end
            end
        end
        set_defaults();
        mask_en   = 1'b1;
        mask_bits = 32'd0;
        cnt_reg   = 64'd1;
        run_op("R4", "all lanes masked merge");
    endtask

    task automatic t_legacy();
        for (int es = 0; es < 3; es++) begin
            set_defaults();
            ext_mode  = 1'b0;
            esize_sel = 2'(es);
            vlen_sel  = 2'(es);
            mask_en   = 1'b1;
            zero_mode = 1'b1;
            mask_bits = 32'h0;
            bcast_en  = 1'b1;
            use_imm   = 1'b1;
            cnt_imm   = 8'd5;
            run_op("R6", "legacy shifts old dst, upper kept");
        end
    endtask

    task automatic t_bcast();
        for (int es = 0; es < 3; es++) begin
            set_defaults();
            esize_sel = 2'(es);
            bcast_en  = 1'b1;
            use_imm   = 1'b1;
            cnt_imm   = 8'd2;
            run_op("R7", "broadcast with imm");
            use_imm = 1'b0;
            cnt_reg = 64'd2;
            run_op("R7", "broadcast ignored with register count");
        end
    endtask

    task automatic t_illegal();
        set_defaults();
        esize_sel = 2'd3;
        cnt_reg   = 64'd1;
        run_op("R8", "size code 3");
        set_defaults();
        vlen_sel = 2'd3;
        run_op("R8", "length code 3");
        set_defaults();
        ext_mode = 1'b0;
        vlen_sel = 2'd3;
        run_op("R8", "length code 3 legacy");
    endtask

    task automatic t_handshake();
        logic [511:0] exp_a, exp_b, held;
        set_defaults();
        cnt_reg = 64'd7;
        exp_a   = ref_calc();
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        chk("R9", "back-to-back first", out_data, exp_a);
        src_vec   = rand512();
        esize_sel = 2'd2;
        exp_b     = ref_calc();
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9", "back-to-back second", out_data, exp_b);
        chk("R9", "back-to-back valid", {511'd0, out_valid}, {511'd0, 1'b1});
        held    = out_data;
        src_vec = rand512();
        @(negedge clk);
        chk("R9", "idle valid low", {511'd0, out_valid}, '0);
        chk("R9", "idle data held", out_data, held);
    endtask

    initial begin
        in_valid = 1'b0;
        t_reset();
        t_sweep();
        t_regcount();
        t_mask();
        t_legacy();
        t_bcast();
        t_illegal();
        t_handshake();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
        $finish;
    end

endmodule